// File: doc/BRIEF.md
# Per-Priority Pause Flow Controller

This block sits beside the ingress buffer of one switch port and decides, separately for each of eight traffic priority classes, when the upstream neighbour must stop sending that class and when it may start again. Each class compares its buffer occupancy against a shared stop level and a lower restart level. A class that crosses the stop level produces a pause request. The request carries a hold time, in quanta, that the upstream device must honour. While the class stays congested, the pause is renewed before the upstream timer runs out. Once the backlog drains below the restart level, the block produces a resume request. A resume is a request whose time field is zero.

All pause and resume events raised in the same cycle are merged into one request. The request holds an eight-bit class vector and a 16-bit time field for every class, ready for a frame builder to turn into a per-priority pause frame. A stall watchdog runs while a class is paused. If a class remains paused too long, it is moved into a disabled state and a one-cycle fault pulse is raised. It stays disabled until its clear bit is driven. A build-time class mask selects which classes may pause at all. By default only class 3, the lossless RDMA class, is enabled.

Top module: `prio_pause_ctrl`

## Requirements
- R1: Each class keeps its own state (running, paused, disabled); a pause, resume or disable of one class leaves the state and requests of every other class unchanged.
- R2: A class whose bit in parameter CLASS_MASK is 0 (default mask 8'h08, class 3 only) never pauses and never raises a request, whatever its occupancy.
- R3: A running, enabled class whose occupancy is strictly greater than the XOFF level enters the paused state at the next clock edge. In the same cycle that the state changes, req_valid_o is high, its bit in req_en_o is set, and its time field equals quanta_i as sampled at that edge.
- R4: A paused class whose occupancy is strictly less than the XON level returns to running at the next edge. In the same cycle it raises a request with its enable bit set and its time field zero.
- R5: A paused class whose occupancy is at or between the two levels stays paused and raises nothing, unless R6 or R7 applies.
- R6: A paused class counts the edges since its last pause request. At an edge where this count is at least quanta_i>>1 and occupancy is still above XOFF, the pause request is sent again and the count restarts. With a constant quanta Q, the renewals therefore come every (Q>>1)+1 cycles.
- R7: A paused class counts the edges since it entered the paused state. At an edge where this count is at least wdog_limit_i, the class moves to disabled instead of resuming or renewing. With a constant limit L, the class is paused for exactly L+1 cycles.
- R8: fault_o is high for exactly the one cycle in which one or more classes have just entered the disabled state. Entering the disabled state raises no request.
- R9: A disabled class ignores occupancy and stays disabled until its bit of dis_clear_i is high at an edge, after which it is running. A clear bit for a class that is not disabled has no effect.
- R10: Requests are one-cycle pulses. Every class with an event in a cycle appears in the same request. A class with no event has enable bit 0 and time field 0. Class i uses bits [16*i +: 16] of req_time_o and bits [16*i +: 16] of occ_i.
- R11: After reset, all outputs are zero and every class is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| occ_i | input | NUM_CLASS*OCC_W | Buffer occupancy per class, class i in slice i |
| xoff_thr_i | input | OCC_W | Stop level: pause when occupancy exceeds it |
| xon_thr_i | input | OCC_W | Restart level: resume when occupancy falls below it |
| quanta_i | input | TIME_W | Hold time placed in pause requests |
| wdog_limit_i | input | WDOG_W | Pause duration, in cycles, that trips the watchdog |
| dis_clear_i | input | NUM_CLASS | Per-class release from the disabled state |
| req_valid_o | output | 1 | A pause/resume request is present this cycle |
| req_en_o | output | NUM_CLASS | Classes addressed by the request |
| req_time_o | output | NUM_CLASS*TIME_W | Per-class hold time, zero for resume or no event |
| paused_o | output | NUM_CLASS | Class is currently paused |
| disabled_o | output | NUM_CLASS | Class is disabled by the watchdog |
| fault_o | output | 1 | Pulse: a class has just been disabled |

## Verification
The assertions assume that xon_thr_i is below xoff_thr_i. They also assume that the threshold, quanta and limit inputs stay steady long enough for a pause episode to be meaningful, so that renewals and watchdog trips follow the counts above. The stimulus keeps XON below XOFF whenever it changes the levels. It changes the levels, quanta and limit only occasionally between random-walk occupancy updates. Clear pulses are sparse, so that disabled episodes last long enough to be observed.

// File: rtl/ppc_pkg.sv
package ppc_pkg;

  typedef enum logic [1:0] {
    CLS_RUN    = 2'd0,
    CLS_PAUSED = 2'd1,
    CLS_OFF    = 2'd2
  } cls_state_e;

endpackage

// File: rtl/ppc_class_fsm.sv
module ppc_class_fsm
  import ppc_pkg::*;
#(
  parameter int  OCC_W  = 16,
  parameter int  TIME_W = 16,
  parameter int  WDOG_W = 24,
  parameter bit  ENABLE = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OCC_W-1:0]  occ_i,
  input  logic [OCC_W-1:0]  xoff_i,
  input  logic [OCC_W-1:0]  xon_i,
  input  logic [TIME_W-1:0] quanta_i,
  input  logic [WDOG_W-1:0] wdog_lim_i,
  input  logic              clear_i,
  output logic              pause_evt_o,
  output logic              resume_evt_o,
  output logic [TIME_W-1:0] time_o,
  output logic              fault_o,
  output logic              paused_o,
  output logic              disabled_o
);

  cls_state_e        state_q, state_d;
  logic [WDOG_W-1:0] wcnt_q, wcnt_d;
  logic              wcnt_en;
  logic [TIME_W-1:0] rcnt_q, rcnt_d;
  logic              rcnt_en;
  logic              pev_q, pev_d;
  logic              rev_q, rev_d;
  logic              flt_q, flt_d;
  logic [TIME_W-1:0] time_q, time_d;

  logic              above_xoff;
  logic              below_xon;
  logic              wd_hit;
  logic [TIME_W-1:0] half_quanta;

  assign above_xoff  = ENABLE && (occ_i > xoff_i);
  assign below_xon   = occ_i < xon_i;
  assign wd_hit      = wcnt_q >= wdog_lim_i;
  assign half_quanta = quanta_i >> 1;

  // next-state process
  always_comb begin
    state_d = state_q;
    wcnt_d  = wcnt_q;
    wcnt_en = 1'b0;
    rcnt_d  = rcnt_q;
    rcnt_en = 1'b0;
    pev_d   = 1'b0;
    rev_d   = 1'b0;
    flt_d   = 1'b0;
    unique case (state_q)
      CLS_RUN: begin
        if (above_xoff) begin
          state_d = CLS_PAUSED;
          wcnt_d  = '0;
          wcnt_en = 1'b1;
          rcnt_d  = '0;
          rcnt_en = 1'b1;
          pev_d   = 1'b1;
        end
      end
      CLS_PAUSED: begin
        if (wd_hit) begin
          state_d = CLS_OFF;
          flt_d   = 1'b1;
        end else if (below_xon) begin
          state_d = CLS_RUN;
          rev_d   = 1'b1;
        end else begin
          wcnt_d  = wcnt_q + WDOG_W'(1);
          wcnt_en = 1'b1;
          if (above_xoff && (rcnt_q >= half_quanta)) begin
            pev_d   = 1'b1;
            rcnt_d  = '0;
            rcnt_en = 1'b1;
          end else if (rcnt_q != '1) begin
            rcnt_d  = rcnt_q + TIME_W'(1);
            rcnt_en = 1'b1;
          end
        end
      end
      CLS_OFF: begin
        if (clear_i) state_d = CLS_RUN;
      end
      default: state_d = CLS_RUN;
    endcase
    time_d = pev_d ? quanta_i : '0;
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CLS_RUN;
      wcnt_q  <= '0;
      rcnt_q  <= '0;
      pev_q   <= 1'b0;
      rev_q   <= 1'b0;
      flt_q   <= 1'b0;
      time_q  <= '0;
    end else begin
      state_q <= state_d;
      if (wcnt_en) wcnt_q <= wcnt_d;
      if (rcnt_en) rcnt_q <= rcnt_d;
      pev_q   <= pev_d;
      rev_q   <= rev_d;
      flt_q   <= flt_d;
      time_q  <= time_d;
    end
  end

  assign pause_evt_o  = pev_q;
  assign resume_evt_o = rev_q;
  assign time_o       = time_q;
  assign fault_o      = flt_q;
  assign paused_o     = (state_q == CLS_PAUSED);
  assign disabled_o   = (state_q == CLS_OFF);

  // R3: entry into the paused state is always announced by a pause request
  a_r3_pause_announced: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(paused_o) |-> pause_evt_o);

  // R4: a resume only leaves a class that was paused, and it is running after
  a_r4_resume_from_paused: assert property (@(posedge clk) disable iff (!rst_n)
    resume_evt_o |-> ($past(state_q) == CLS_PAUSED) && !paused_o && !disabled_o);

  // R8: the disabled state is entered from pause, with a fault pulse, no request
  a_r8_disable_with_fault: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(disabled_o) |-> ($past(state_q) == CLS_PAUSED) && fault_o && !pause_evt_o && !resume_evt_o);

  // R9: without a clear, a disabled class stays disabled
  a_r9_disabled_holds: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(disabled_o) && !$past(clear_i)) |-> disabled_o);

  // R10: pause and resume never coincide for one class
  a_r10_single_event: assert property (@(posedge clk) disable iff (!rst_n)
    !(pause_evt_o && resume_evt_o));

  generate
    if (!ENABLE) begin : g_masked_chk
      // R2: a masked class never leaves the running state
      a_r2_masked_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !paused_o && !pause_evt_o);
    end
  endgenerate

endmodule

// File: rtl/ppc_req_merge.sv
module ppc_req_merge #(
  parameter int NUM_CLASS = 8,
  parameter int TIME_W    = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_CLASS-1:0]        pause_evt_i,
  input  logic [NUM_CLASS-1:0]        resume_evt_i,
  input  logic [NUM_CLASS*TIME_W-1:0] time_i,
  input  logic [NUM_CLASS-1:0]        fault_i,
  output logic                        req_valid_o,
  output logic [NUM_CLASS-1:0]        req_en_o,
  output logic [NUM_CLASS*TIME_W-1:0] req_time_o,
  output logic                        fault_o
);

  logic [NUM_CLASS-1:0] en_vec;

  always_comb begin
    en_vec = pause_evt_i | resume_evt_i;
  end

  assign req_en_o    = en_vec;
  assign req_valid_o = |en_vec;
  assign req_time_o  = time_i;
  assign fault_o     = |fault_i;

  // R10: a nonzero time field only ever belongs to an addressed class
  generate
    for (genvar g = 0; g < NUM_CLASS; g++) begin : g_time_chk
      a_r10_time_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (time_i[g*TIME_W +: TIME_W] != '0) |-> pause_evt_i[g]);
    end
  endgenerate

endmodule

// File: rtl/prio_pause_ctrl.sv
module prio_pause_ctrl
  import ppc_pkg::*;
#(
  parameter int                 NUM_CLASS  = 8,
  parameter int                 OCC_W      = 16,
  parameter int                 TIME_W     = 16,
  parameter int                 WDOG_W     = 24,
  parameter logic [NUM_CLASS-1:0] CLASS_MASK = 8'h08
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_CLASS*OCC_W-1:0]  occ_i,
  input  logic [OCC_W-1:0]            xoff_thr_i,
  input  logic [OCC_W-1:0]            xon_thr_i,
  input  logic [TIME_W-1:0]           quanta_i,
  input  logic [WDOG_W-1:0]           wdog_limit_i,
  input  logic [NUM_CLASS-1:0]        dis_clear_i,
  output logic                        req_valid_o,
  output logic [NUM_CLASS-1:0]        req_en_o,
  output logic [NUM_CLASS*TIME_W-1:0] req_time_o,
  output logic [NUM_CLASS-1:0]        paused_o,
  output logic [NUM_CLASS-1:0]        disabled_o,
  output logic                        fault_o
);

  localparam int TIME_BUS_W = NUM_CLASS * TIME_W;

  logic [NUM_CLASS-1:0]  pev;
  logic [NUM_CLASS-1:0]  rev;
  logic [NUM_CLASS-1:0]  flt;
  logic [TIME_BUS_W-1:0] time_bus;

  generate
    for (genvar g = 0; g < NUM_CLASS; g++) begin : g_class
      ppc_class_fsm #(
        .OCC_W  (OCC_W),
        .TIME_W (TIME_W),
        .WDOG_W (WDOG_W),
        .ENABLE (CLASS_MASK[g])
      ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .occ_i        (occ_i[g*OCC_W +: OCC_W]),
        .xoff_i       (xoff_thr_i),
        .xon_i        (xon_thr_i),
        .quanta_i     (quanta_i),
        .wdog_lim_i   (wdog_limit_i),
        .clear_i      (dis_clear_i[g]),
        .pause_evt_o  (pev[g]),
        .resume_evt_o (rev[g]),
        .time_o       (time_bus[g*TIME_W +: TIME_W]),
        .fault_o      (flt[g]),
        .paused_o     (paused_o[g]),
        .disabled_o   (disabled_o[g])
      );

      // R3: every addressed class that is not paused afterwards carries time zero (a resume)
      a_r3_pause_lands_paused: assert property (@(posedge clk) disable iff (!rst_n)
        (req_en_o[g] && !paused_o[g]) |-> (req_time_o[g*TIME_W +: TIME_W] == '0));
    end
  endgenerate

  ppc_req_merge #(
    .NUM_CLASS (NUM_CLASS),
    .TIME_W    (TIME_W)
  ) u_merge (
    .clk          (clk),
    .rst_n        (rst_n),
    .pause_evt_i  (pev),
    .resume_evt_i (rev),
    .time_i       (time_bus),
    .fault_i      (flt),
    .req_valid_o  (req_valid_o),
    .req_en_o     (req_en_o),
    .req_time_o   (req_time_o),
    .fault_o      (fault_o)
  );

  // R8: a fault pulse always comes with a disabled class
  a_r8_fault_has_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> (disabled_o != '0));

  // R1: a class is never paused and disabled together
  a_r1_state_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    (paused_o & disabled_o) == '0);

endmodule

// File: tb/prio_pause_ctrl_bench.sv
module prio_pause_ctrl_bench;

  localparam int          CLK_P  = 10;
  localparam int          NC     = 8;
  localparam int          OW     = 16;
  localparam int          TW     = 16;
  localparam int          WW     = 24;
  localparam logic [7:0]  MASK   = 8'b1010_1101;

  logic              clk;
  logic              rst_n;
  logic [NC*OW-1:0]  occ_flat;
  logic [OW-1:0]     xoff, xon;
  logic [TW-1:0]     quanta;
  logic [WW-1:0]     wlim;
  logic [NC-1:0]     clr;
  logic              req_valid;
  logic [NC-1:0]     req_en;
  logic [NC*TW-1:0]  req_time;
  logic [NC-1:0]     paused, disabled;
  logic              fault;

  prio_pause_ctrl #(
    .NUM_CLASS (NC), .OCC_W (OW), .TIME_W (TW), .WDOG_W (WW), .CLASS_MASK (MASK)
  ) u_prio_pause_ctrl (
    .clk (clk), .rst_n (rst_n), .occ_i (occ_flat), .xoff_thr_i (xoff),
    .xon_thr_i (xon), .quanta_i (quanta), .wdog_limit_i (wlim),
    .dis_clear_i (clr), .req_valid_o (req_valid), .req_en_o (req_en),
    .req_time_o (req_time), .paused_o (paused), .disabled_o (disabled),
    .fault_o (fault)
  );

  int n_chk;
  int n_fail;
  bit done;
  int occ [NC];

  // reference model state: 0 run, 1 paused, 2 disabled
  int          m_st [NC];
  int unsigned m_wc [NC];
  int unsigned m_rc [NC];
  bit          e_valid;
  bit [NC-1:0] e_en, e_paused, e_dis;
  bit [NC*TW-1:0] e_time;
  bit          e_fault;

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic chk(string tag, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit model_above(int i);
    return MASK[i] && (occ[i] > int'(xoff));
  endfunction

  // one clock edge of the requirement model
  task automatic model_step();
    e_en = '0; e_time = '0; e_fault = 1'b0;
    for (int i = 0; i < NC; i++) begin
      bit p, r;
      p = 0; r = 0;
      case (m_st[i])
        0: if (model_above(i)) begin m_st[i] = 1; m_wc[i] = 0; m_rc[i] = 0; p = 1; end
        1: begin
          if (m_wc[i] >= wlim) begin m_st[i] = 2; e_fault = 1'b1; end       // R7 R8
          else if (occ[i] < int'(xon)) begin m_st[i] = 0; r = 1; end         // R4
          else begin
            m_wc[i]++;
            if (model_above(i) && m_rc[i] >= (quanta >> 1)) begin p = 1; m_rc[i] = 0; end  // R6
            else if (m_rc[i] != 32'hFFFF) m_rc[i]++;
          end
        end
        default: if (clr[i]) m_st[i] = 0;                                    // R9
      endcase
      e_en[i] = p | r;
      if (p) e_time[i*TW +: TW] = quanta;
      e_paused[i] = (m_st[i] == 1);
      e_dis[i]    = (m_st[i] == 2);
    end
    e_valid = |e_en;
  endtask

  task automatic tick();
    for (int i = 0; i < NC; i++) occ_flat[i*OW +: OW] = OW'(occ[i]);
    model_step();
    @(posedge clk);
    @(negedge clk);
    chk("R3 R4 R10 req_valid", req_valid, e_valid);
    chk("R1 R2 R3 R4 R6 R10 req_en", req_en, e_en);
    chk("R3 R6 R10 req_time", req_time, e_time);
    chk("R1 R5 R7 R9 paused", paused, e_paused);
    chk("R7 R9 disabled", disabled, e_dis);
    chk("R8 fault", fault, e_fault);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd20260308);
    n_chk = 0; n_fail = 0; done = 0;
    rst_n = 1'b0; occ_flat = '0; xoff = 100; xon = 50; quanta = 8; wlim = 1000; clr = '0;
    for (int i = 0; i < NC; i++) begin occ[i] = 0; m_st[i] = 0; m_wc[i] = 0; m_rc[i] = 0; end
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11 reset outputs", {req_valid, req_en, paused, disabled, fault}, 0);
    chk("R11 reset time", req_time, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 pause then R6 renewals
    occ[3] = 120;
    tick();
    chk("R3 pause time class3", req_time[3*TW +: TW], 8);
    chk("R3 pause enable class3", req_en, 8'h08);
    for (int k = 0; k < 12; k++) tick();
    // R5 hysteresis band
    occ[3] = 70;
    for (int k = 0; k < 6; k++) tick();
    chk("R5 still paused in band", paused[3], 1);
    // R4 resume
    occ[3] = 40;
    tick();
    chk("R4 resume request", req_en[3], 1);
    chk("R4 resume time zero", req_time[3*TW +: TW], 0);

    // R1 independence
    occ[0] = 120;
    tick();
    chk("R1 only class0 paused", paused, 8'h01);
    occ[0] = 0;
    tick();

    // R2 masked class ignores occupancy
    occ[1] = 250; occ[6] = 250;
    for (int k = 0; k < 3; k++) tick();
    chk("R2 masked classes idle", paused & 8'h42, 0);
    occ[1] = 0; occ[6] = 0;

    // R7 watchdog, R8 fault, R9 clear
    wlim = 20; occ[5] = 200;
    for (int k = 0; k < 21; k++) tick();
    chk("R7 paused through limit", paused[5], 1);
    tick();
    chk("R7 disabled after limit+1", disabled[5], 1);
    chk("R8 fault pulse", fault, 1);
    occ[5] = 0;
    for (int k = 0; k < 3; k++) tick();
    chk("R9 disabled ignores drain", disabled[5], 1);
    clr[2] = 1'b1;
    tick();
    clr[2] = 1'b0;
    chk("R9 clear of running class no effect", {paused[2], disabled[2]}, 0);
    clr[5] = 1'b1;
    tick();
    clr[5] = 1'b0;
    chk("R9 clear releases", disabled[5], 0);

    // random phase
    wlim = 150;
    for (int n = 0; n < 6000; n++) begin
      for (int i = 0; i < NC; i++) begin
        occ[i] = occ[i] + int'($urandom_range(0, 40)) - 20;
        if (occ[i] < 0) occ[i] = 0;
        if (occ[i] > 300) occ[i] = 300;
        clr[i] = ($urandom_range(0, 60) == 0);
      end
      if ($urandom_range(0, 400) == 0) begin
        xoff   = OW'($urandom_range(60, 200));
        xon    = OW'($urandom_range(0, int'(xoff) - 1));
        quanta = TW'($urandom_range(0, 24));
        wlim   = WW'($urandom_range(10, 200));
      end
      tick();
    end
    clr = '0;

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule